// File: doc/BRIEF.md
# Buffered Serial Transmitter with FIFO Level Status

This block is the send half of an asynchronous serial port. Characters of up to nine bits are written into a sixteen-entry queue. A shift engine takes them out one at a time and sends each one as a frame on a single output line. Every bit of a frame lasts sixteen pulses of an external oversampling tick. The frame layout (character size and parity) and the stop length are set by configuration inputs. The stop length can be set in half-bit steps.

Software or a bus front end watches a ten-bit status word that reports four conditions:

- the queue is non-empty;
- the queue is at least half empty;
- the queue is full;
- the whole transmitter has gone quiet.

An interrupt line is the OR of the status bits that are enabled. A global run control must be set for anything to be sent. An optional clear-to-send gate, driven by an active-low input, can hold back the next frame. A flush pulse discards every queued character.

Top module: `txq_serializer`

## Requirements
- R1: After reset txd_o is 1, status_o equals 10'h006 (only bits 1 and 2 set), and irq_o is 0 while irq_en_i is 0.
- R2: A frame is a low start bit, then the payload least significant bit first, each bit held for 16 ticks. fmt_i selects the payload: 00 sends 8 data bits; 01 sends 7 data bits plus parity; 10 sends 8 data bits plus parity; 11 sends 9 data bits. The parity bit makes the count of ones even when parity_odd_i is 0, and odd when it is 1.
- R3: The line stays high after the payload for a stop time set by stop_sel_i: 00 gives 8 ticks, 01 gives 16, 10 gives 24 and 11 gives 32. A queued character starts its start bit before the next tick, with no gap after the stop time.
- R4: The queue holds 16 characters. A write while it holds 16 is dropped, even if a character leaves in the same cycle. Characters leave in write order.
- R5: status_o bit 6 is 1 while the queue is non-empty. Bit 2 is 1 while it holds 8 or fewer characters. Bit 9 is 1 while it holds 16. All other bits of status_o except bit 1 read 0.
- R6: status_o bit 1 is 1 only while the queue is empty and no frame is in progress, which includes its stop time.
- R7: irq_o equals the OR over all ten bits of status_o AND irq_en_i.
- R8: While cts_en_i is 1 and cts_ni is 1, no new frame starts, but a frame already started completes. While cts_en_i is 0, cts_ni has no effect.
- R9: While run_i is 0, no frame starts and a frame in progress does not advance.
- R10: A flush_i pulse empties the queue, and a write in the same cycle is dropped. A frame already in progress completes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| tick16_i | input | 1 | Oversampling tick, one pulse per sixteenth of a bit |
| run_i | input | 1 | Global enable for starting and advancing frames |
| fmt_i | input | 2 | Payload format code |
| parity_odd_i | input | 1 | Odd parity when 1, even parity when 0 |
| stop_sel_i | input | 2 | Stop time in half-bit steps |
| cts_en_i | input | 1 | Enable for the clear-to-send gate |
| cts_ni | input | 1 | Clear to send, active low |
| wr_en_i | input | 1 | Write strobe for one character |
| wr_data_i | input | 9 | Character to queue |
| flush_i | input | 1 | Discard all queued characters |
| irq_en_i | input | 10 | Interrupt enable, same bit positions as status_o |
| txd_o | output | 1 | Serial line, idle high |
| status_o | output | 10 | Level and activity status |
| irq_o | output | 1 | Interrupt request |

## Verification
The bench goes after these corner cases, each paired with what a wrong design would do:

- **Half-empty boundary at eight and nine entries.** An off-by-one compare would show bit 2 at nine entries or lose it at eight.
- **Seventeenth write into a full queue.** A design that wrapped its pointer would overwrite the oldest entry, and that entry would come out of the drain corrupted.
- **Status during the last stop time.** A design that looked only at the queue would report the transmitter empty while the stop bit is still on the line.
- **Clear-to-send dropping in the middle of a frame.** A design that aborted the frame would cut the character short.
- **Clear-to-send ignored while its gate is off.**
- **Flush landing during a frame.** Aborting the frame on a flush would lose the character already on the line.
- **Random bursts over every format and stop setting.** A swapped parity sense or a mis-scaled stop count would show up as a wrong payload or a wrong high-run length between frames.

// File: rtl/txq_pkg.sv
package txq_pkg;
    localparam int unsigned CHAR_W = 9;
    localparam int unsigned STAT_W = 10;

    localparam int unsigned ST_TXEMPTY = 1;
    localparam int unsigned ST_HALF    = 2;
    localparam int unsigned ST_NEMPTY  = 6;
    localparam int unsigned ST_FULL    = 9;

    localparam logic [1:0] FMT_D8    = 2'b00;
    localparam logic [1:0] FMT_D7P   = 2'b01;
    localparam logic [1:0] FMT_D8P   = 2'b10;
    localparam logic [1:0] FMT_D9    = 2'b11;

    typedef enum logic [1:0] {
        SH_IDLE  = 2'd0,
        SH_START = 2'd1,
        SH_DATA  = 2'd2,
        SH_STOP  = 2'd3
    } sh_state_e;
endpackage

// File: rtl/txq_fifo.sv
module txq_fifo #(
    parameter int unsigned DATA_W = 9,
    parameter int unsigned DEPTH  = 16,
    localparam int unsigned PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int unsigned CNT_W = $clog2(DEPTH + 1)
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              push_i,
    input  logic [DATA_W-1:0] push_data_i,
    input  logic              pop_i,
    input  logic              flush_i,
    output logic [DATA_W-1:0] rd_data_o,
    output logic [CNT_W-1:0]  count_o,
    output logic              full_o,
    output logic              empty_o
);
    typedef struct packed {
        logic [PTR_W-1:0] wptr;
        logic [PTR_W-1:0] rptr;
        logic [CNT_W-1:0] count;
    } fifo_state_t;

    fifo_state_t q, d;
    logic [DATA_W-1:0] mem_q [DEPTH];
    logic do_push, do_pop;

    function automatic logic [PTR_W-1:0] ptr_inc(input logic [PTR_W-1:0] p);
        return (p == PTR_W'(DEPTH - 1)) ? '0 : p + PTR_W'(1);
    endfunction

    assign full_o  = (q.count == CNT_W'(DEPTH));
    assign empty_o = (q.count == '0);
    assign do_push = push_i && !full_o && !flush_i;
    assign do_pop  = pop_i && !empty_o && !flush_i;

    always_comb begin
        d = q;
        if (flush_i) begin
            d.wptr  = '0;
            d.rptr  = '0;
            d.count = '0;
        end else begin
            if (do_push) d.wptr = ptr_inc(q.wptr);
            if (do_pop)  d.rptr = ptr_inc(q.rptr);
            case ({do_push, do_pop})
                2'b10:   d.count = q.count + CNT_W'(1);
                2'b01:   d.count = q.count - CNT_W'(1);
                default: d.count = q.count;
            endcase
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) q <= '0;
        else         q <= d;
    end

    always_ff @(posedge clk_i) begin
        if (do_push) mem_q[q.wptr] <= push_data_i;
    end

    assign rd_data_o = mem_q[q.rptr];
    assign count_o   = q.count;

    // R4: occupancy never exceeds the depth
    p_count_range_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        q.count <= CNT_W'(DEPTH));

    // R4: a write into a full queue with nothing leaving changes nothing
    p_full_drop_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (full_o && push_i && !pop_i && !flush_i) |=> (q.count == CNT_W'(DEPTH)));

    // R10: a flush leaves the queue empty
    p_flush_clear_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
        flush_i |=> (q.count == '0));
endmodule

// File: rtl/txq_shifter.sv
module txq_shifter
    import txq_pkg::*;
#(
    parameter int unsigned BIT_TICKS = 16,
    localparam int unsigned HALF_TICKS = BIT_TICKS / 2,
    localparam int unsigned CNT_W = $clog2(2 * BIT_TICKS + 1)
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              tick_i,
    input  logic              run_i,
    input  logic              cts_en_i,
    input  logic              cts_ni,
    input  logic [1:0]        fmt_i,
    input  logic              parity_odd_i,
    input  logic [1:0]        stop_sel_i,
    input  logic              avail_i,
    input  logic [CHAR_W-1:0] char_i,
    output logic              pop_o,
    output logic              busy_o,
    output logic              txd_o
);
    typedef struct packed {
        sh_state_e        state;
        logic [CNT_W-1:0] cnt;
        logic [CNT_W-1:0] stop_lim;
        logic [3:0]       bit_idx;
        logic [3:0]       len;
        logic [CHAR_W-1:0] sh;
    } sh_regs_t;

    sh_regs_t q, d;
    logic go, adv, par7, par8;

    assign go   = run_i && (!cts_en_i || !cts_ni);
    assign adv  = tick_i && run_i;
    assign par7 = (^char_i[6:0]) ^ parity_odd_i;
    assign par8 = (^char_i[7:0]) ^ parity_odd_i;

    always_comb begin
        d     = q;
        pop_o = 1'b0;
        case (q.state)
            SH_IDLE: begin
                if (go && avail_i) begin
                    pop_o      = 1'b1;
                    d.state    = SH_START;
                    d.cnt      = '0;
                    d.bit_idx  = '0;
                    d.stop_lim = CNT_W'((int'(stop_sel_i) + 1) * HALF_TICKS);
                    case (fmt_i)
                        FMT_D8:  begin d.sh = {1'b0, char_i[7:0]};       d.len = 4'd8; end
                        FMT_D7P: begin d.sh = {1'b0, par7, char_i[6:0]}; d.len = 4'd8; end
                        FMT_D8P: begin d.sh = {par8, char_i[7:0]};       d.len = 4'd9; end
                        default: begin d.sh = char_i;                    d.len = 4'd9; end
                    endcase
                end
            end
            SH_START: begin
                if (adv) begin
                    if (q.cnt == CNT_W'(BIT_TICKS - 1)) begin
                        d.state = SH_DATA;
                        d.cnt   = '0;
                    end else begin
                        d.cnt = q.cnt + CNT_W'(1);
                    end
                end
            end
            SH_DATA: begin
                if (adv) begin
                    if (q.cnt == CNT_W'(BIT_TICKS - 1)) begin
                        d.cnt = '0;
                        d.sh  = q.sh >> 1;
                        if (q.bit_idx == q.len - 4'd1) d.state = SH_STOP;
                        else d.bit_idx = q.bit_idx + 4'd1;
                    end else begin
                        d.cnt = q.cnt + CNT_W'(1);
                    end
                end
            end
            default: begin
                if (adv) begin
                    if (q.cnt == q.stop_lim - CNT_W'(1)) begin
                        d.state = SH_IDLE;
                        d.cnt   = '0;
                    end else begin
                        d.cnt = q.cnt + CNT_W'(1);
                    end
                end
            end
        endcase
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            q       <= '0;
            q.state <= SH_IDLE;
        end else begin
            q <= d;
        end
    end

    assign busy_o = (q.state != SH_IDLE);
    assign txd_o  = (q.state == SH_START) ? 1'b0 :
                    (q.state == SH_DATA)  ? q.sh[0] : 1'b1;

    // R8: with the gate closed an idle shifter stays idle
    p_cts_hold_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (q.state == SH_IDLE && cts_en_i && cts_ni) |=> (q.state == SH_IDLE));

    // R9: with run cleared nothing moves
    p_run_freeze_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !run_i |=> ($stable(q.state) && $stable(q.cnt)));

    // R4: a character is only taken when the queue offers one
    p_pop_valid_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        pop_o |-> avail_i);

    // R2: a frame always begins with the start state
    p_start_first_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (q.state == SH_IDLE) |=> (q.state == SH_IDLE || q.state == SH_START));
endmodule

// File: rtl/txq_serializer.sv
module txq_serializer
    import txq_pkg::*;
#(
    parameter int unsigned DEPTH     = 16,
    parameter int unsigned BIT_TICKS = 16,
    localparam int unsigned CNT_W    = $clog2(DEPTH + 1)
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              tick16_i,
    input  logic              run_i,
    input  logic [1:0]        fmt_i,
    input  logic              parity_odd_i,
    input  logic [1:0]        stop_sel_i,
    input  logic              cts_en_i,
    input  logic              cts_ni,
    input  logic              wr_en_i,
    input  logic [CHAR_W-1:0] wr_data_i,
    input  logic              flush_i,
    input  logic [STAT_W-1:0] irq_en_i,
    output logic              txd_o,
    output logic [STAT_W-1:0] status_o,
    output logic              irq_o
);
    logic [CHAR_W-1:0] head;
    logic [CNT_W-1:0]  level;
    logic full, empty, pop, busy;
    logic [STAT_W-1:0] irq_terms;

    txq_fifo #(.DATA_W(CHAR_W), .DEPTH(DEPTH)) i_fifo (
        .clk_i       (clk_i),
        .rst_ni      (rst_ni),
        .push_i      (wr_en_i),
        .push_data_i (wr_data_i),
        .pop_i       (pop),
        .flush_i     (flush_i),
        .rd_data_o   (head),
        .count_o     (level),
        .full_o      (full),
        .empty_o     (empty)
    );

    txq_shifter #(.BIT_TICKS(BIT_TICKS)) i_shifter (
        .clk_i        (clk_i),
        .rst_ni       (rst_ni),
        .tick_i       (tick16_i),
        .run_i        (run_i),
        .cts_en_i     (cts_en_i),
        .cts_ni       (cts_ni),
        .fmt_i        (fmt_i),
        .parity_odd_i (parity_odd_i),
        .stop_sel_i   (stop_sel_i),
        .avail_i      (!empty),
        .char_i       (head),
        .pop_o        (pop),
        .busy_o       (busy),
        .txd_o        (txd_o)
    );

    always_comb begin
        status_o             = '0;
        status_o[ST_TXEMPTY] = empty && !busy;
        status_o[ST_HALF]    = (level <= CNT_W'(DEPTH / 2));
        status_o[ST_NEMPTY]  = !empty;
        status_o[ST_FULL]    = full;
    end

    for (genvar b = 0; b < STAT_W; b++) begin : g_irq
        assign irq_terms[b] = status_o[b] & irq_en_i[b];
    end
    assign irq_o = |irq_terms;

    // R5: the full and half-empty levels exclude each other
    p_full_not_half_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        status_o[ST_FULL] |-> !status_o[ST_HALF]);

    // R6: a quiet transmitter holds the line high
    p_quiet_line_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        status_o[ST_TXEMPTY] |-> txd_o);
endmodule

// File: tb/test_txq_serializer.sv
module test_txq_serializer;
    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic       rst_n = 1'b0;
    logic       tick16 = 1'b0;
    logic       run = 1'b0;
    logic [1:0] fmt = 2'b00;
    logic       podd = 1'b0;
    logic [1:0] stop_sel = 2'b01;
    logic       cts_en = 1'b0;
    logic       cts_n = 1'b0;
    logic       wr_en = 1'b0;
    logic [8:0] wr_data = '0;
    logic       flush = 1'b0;
    logic [9:0] irq_en = '0;
    logic       txd;
    logic [9:0] status;
    logic       irq;

    txq_serializer i_txq_serializer (
        .clk_i(clk), .rst_ni(rst_n), .tick16_i(tick16), .run_i(run),
        .fmt_i(fmt), .parity_odd_i(podd), .stop_sel_i(stop_sel),
        .cts_en_i(cts_en), .cts_ni(cts_n), .wr_en_i(wr_en),
        .wr_data_i(wr_data), .flush_i(flush), .irq_en_i(irq_en),
        .txd_o(txd), .status_o(status), .irq_o(irq)
    );

    int checks = 0;
    int errors = 0;

    task automatic chk(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    function automatic int exp_len(input int f);
        return (f >= 2) ? 9 : 8;
    endfunction
    function automatic int exp_stop(input int s);
        return (s + 1) * 8;
    endfunction
    function automatic int exp_pay(input int f, input bit odd, input int dv);
        int p7, p8;
        p7 = ($countones(dv & 127) & 1) ^ int'(odd);
        p8 = ($countones(dv & 255) & 1) ^ int'(odd);
        case (f)
            0: return dv & 255;
            1: return (dv & 127) | (p7 << 7);
            2: return (dv & 255) | (p8 << 8);
            default: return dv & 511;
        endcase
    endfunction

    // line monitor sampled once per tick
    int rx_pay[$];
    int rx_stop[$];
    int cur_len = 8;
    int ms = 0, mn = 0, mbi = 0, mhi = 0, mpay = 0;

    task automatic mon(input logic s);
        case (ms)
            0: if (!s) begin ms = 1; mn = 1; end
            1: begin mn++; if (mn == 16) begin ms = 2; mn = 0; mbi = 0; mpay = 0; end end
            2: begin
                mn++;
                if (mn == 8 && s) mpay = mpay | (1 << mbi);
                if (mn == 16) begin
                    mn = 0; mbi++;
                    if (mbi == cur_len) begin ms = 3; mhi = 0; end
                end
            end
            default: begin
                if (s) begin
                    mhi++;
                    if (mhi > 40) begin rx_pay.push_back(mpay); rx_stop.push_back(-1); ms = 0; end
                end else begin
                    rx_pay.push_back(mpay); rx_stop.push_back(mhi); ms = 1; mn = 1;
                end
            end
        endcase
    endtask

    always @(negedge clk) begin
        if (!rst_n) begin
            tick16 = 1'b0; ms = 0;
        end else begin
            tick16 = ~tick16;
            if (tick16) mon(txd);
        end
    end

    task automatic put(input int dv);
        wr_en = 1'b1; wr_data = 9'(dv);
        @(negedge clk);
        wr_en = 1'b0;
        @(negedge clk);
    endtask

    task automatic wait_idle();
        int n = 0;
        while (!status[1] && n < 30000) begin @(negedge clk); n++; end
        repeat (120) @(negedge clk);
    endtask

    task automatic clear_rx();
        rx_pay.delete(); rx_stop.delete();
    endtask

    bit done = 1'b0;

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual 0 expected 1");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        int vals[16];
        int a;
        process::self().srandom(32'd20240611);
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // reset state
        chk("R1", "txd after reset", int'(txd), 1);
        chk("R1", "status after reset", int'(status), 6);
        chk("R1", "irq with no enables", int'(irq), 0);
        irq_en = 10'h004;
        @(negedge clk);
        chk("R7", "irq on half-empty", int'(irq), 1);
        irq_en = 10'h040;
        @(negedge clk);
        chk("R7", "irq on non-empty while empty", int'(irq), 0);

        // fill with run cleared
        fmt = 2'b11; stop_sel = 2'b01; cur_len = 9;
        clear_rx();
        for (int i = 0; i < 16; i++) vals[i] = (9'h100 + i * 37) & 511;
        for (int i = 0; i < 8; i++) put(vals[i]);
        chk("R5", "non-empty at 8", int'(status[6]), 1);
        chk("R5", "half at 8", int'(status[2]), 1);
        chk("R6", "not quiet at 8", int'(status[1]), 0);
        chk("R7", "irq follows non-empty", int'(irq), 1);
        put(vals[8]);
        chk("R5", "half at 9", int'(status[2]), 0);
        irq_en = 10'h004;
        @(negedge clk);
        chk("R7", "irq half at 9", int'(irq), 0);
        for (int i = 9; i < 16; i++) put(vals[i]);
        chk("R5", "full at 16", int'(status[9]), 1);
        chk("R5", "reserved bits", int'(status & 10'h1B9), 0);
        put(9'h0AA);
        repeat (200) @(negedge clk);
        chk("R9", "line idle with run clear", int'(txd), 1);
        chk("R9", "no frames with run clear", rx_pay.size(), 0);
        chk("R4", "still full after extra write", int'(status[9]), 1);
        run = 1'b1;
        wait_idle();
        chk("R4", "drained count", rx_pay.size(), 16);
        for (int i = 0; i < 16 && i < rx_pay.size(); i++)
            chk("R4", "drain order", rx_pay[i], vals[i]);

        // quiet only after the stop time
        clear_rx();
        fmt = 2'b00; cur_len = 8;
        put(9'h05A);
        repeat (10) @(negedge clk);
        chk("R6", "queue empty during frame", int'(status[6]), 0);
        chk("R6", "not quiet during frame", int'(status[1]), 0);
        wait_idle();
        chk("R6", "quiet after frame", int'(status[1]), 1);
        chk("R2", "single frame payload", (rx_pay.size() > 0) ? rx_pay[0] : -9, 16'h5A);

        // flush
        clear_rx();
        put(9'h011); put(9'h022); put(9'h033);
        repeat (30) @(negedge clk);
        flush = 1'b1;
        @(negedge clk);
        flush = 1'b0;
        @(negedge clk);
        chk("R10", "queue empty after flush", int'(status[6]), 0);
        wait_idle();
        chk("R10", "in-flight frame kept", rx_pay.size(), 1);
        chk("R10", "in-flight data", (rx_pay.size() > 0) ? rx_pay[0] : -9, 16'h11);
        run = 1'b0;
        flush = 1'b1; wr_en = 1'b1; wr_data = 9'h077;
        @(negedge clk);
        flush = 1'b0; wr_en = 1'b0;
        @(negedge clk);
        chk("R10", "write with flush dropped", int'(status[6]), 0);
        run = 1'b1;

        // clear-to-send gate
        clear_rx();
        cts_en = 1'b1; cts_n = 1'b1;
        put(9'h0C3);
        repeat (400) @(negedge clk);
        chk("R8", "held by gate", rx_pay.size(), 0);
        chk("R8", "char still queued", int'(status[6]), 1);
        cts_n = 1'b0;
        wait_idle();
        chk("R8", "released frame", (rx_pay.size() > 0) ? rx_pay[0] : -9, 16'hC3);
        clear_rx();
        put(9'h081); put(9'h07E);
        repeat (60) @(negedge clk);
        cts_n = 1'b1;
        repeat (700) @(negedge clk);
        chk("R8", "frame in flight completes", rx_pay.size(), 1);
        chk("R8", "completed data", (rx_pay.size() > 0) ? rx_pay[0] : -9, 16'h81);
        chk("R8", "next held", int'(status[6]), 1);
        cts_en = 1'b0;
        wait_idle();
        chk("R8", "gate off ignores cts", rx_pay.size(), 2);
        chk("R8", "second data", (rx_pay.size() > 1) ? rx_pay[1] : -9, 16'h7E);
        cts_n = 1'b0;

        // random bursts
        for (int b = 0; b < 12; b++) begin
            int n, f, s;
            bit o;
            int dv[6];
            f = int'($urandom % 4); s = int'($urandom % 4); o = 1'($urandom % 2);
            if (b < 4) s = b;
            fmt = 2'(f); stop_sel = 2'(s); podd = o; cur_len = exp_len(f);
            n = 2 + int'($urandom % 4);
            clear_rx();
            for (int i = 0; i < n; i++) begin dv[i] = int'($urandom % 512); put(dv[i]); end
            wait_idle();
            chk("R2", "burst frame count", rx_pay.size(), n);
            for (int i = 0; i < n && i < rx_pay.size(); i++) begin
                chk("R2", "payload bits", rx_pay[i], exp_pay(f, o, dv[i]));
                a = (i < n - 1) ? exp_stop(s) : -1;
                chk("R3", "stop ticks", rx_stop[i], a);
            end
        end

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule